// File: doc/BRIEF.md
# Eager Fork Control Unit

This block is the steering element for a valid/stall handshake channel that fans one producer (the root) out to `BRANCHES` consumers. When the root offers a token, every branch that is not stalled receives it in the same cycle. The block does not wait for the slower branches. Each branch keeps one flag recording whether it still owes a transfer for the current token. The root is held stalled until every branch has taken the token. Then all flags re-arm for the next token.

The block holds no data. A data path placed beside it uses the branch valid outputs as per-branch capture enables. It uses the root stall output to hold the producer's register. The valid and stall outputs are combinational functions of the inputs and the per-branch flags. Only the flags change at a clock edge.

Top module: `efork`

## Requirements
- R1: After reset every branch is pending. With root valid high and no branch stalled, every branch valid output is 1 and root stall is 0.
- R2: While root valid is low, every branch valid output is 0.
- R3: In the same cycle, branch i valid output is 1 exactly when root valid is 1 and branch i has not yet taken the current token. This holds whatever the other branches' stall inputs are.
- R4: Root stall is 1 exactly when at least one branch that has not yet taken the current token has its stall input at 1.
- R5: A branch that transfers (its valid 1, its stall 0) while root stall is 1 shows valid 0 on every later cycle until the root transfer of that token completes.
- R6: In the cycle after a root transfer (root valid 1, root stall 0), every branch is pending again.
- R7: Over any stretch of operation since reset, each branch's transfer count minus the root's transfer count is 0 or 1.
- R8: When root valid is 1 and all branches are stalled at the start of a token, every branch valid output is 1 (retry, not idle), and root stall is 1.
- R9: Cycles with root valid 0 change no branch's pending flag. A branch that took the token before such a cycle is not offered it again afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; sets every branch pending |
| root_valid | input | 1 | Producer offers a token |
| root_stall | output | 1 | Producer must hold its token |
| br_valid | output | BRANCHES | Per-branch token offer; bit i is branch i |
| br_stall | input | BRANCHES | Per-branch refusal; bit i is branch i |

## Verification
The valid and stall outputs are due in the same cycle as the inputs that cause them. The bench therefore drives each input set just after a falling edge and samples the outputs one nanosecond later, before the next rising edge. Effects that pass through the pending flags (R5, R6, R9) become visible in the cycle after the rising edge that follows the causing stimulus. The bench's model applies its state update at that same edge, so it compares against the flags as they stand in the next sampled cycle. The transfer-count bound of R7 is checked after every cycle from running counters kept in the bench.

// File: rtl/efork_pkg.sv
package efork_pkg;

    // State held for one branch of the fork.
    typedef struct packed {
        logic pend;   // 1: branch still owes a transfer for the current token
    } br_state_t;

    localparam br_state_t BR_STATE_RESET = '{pend: 1'b1};

endpackage

// File: rtl/efork_branch.sv
module efork_branch
    import efork_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic root_valid,
    input  logic root_xfer,
    input  logic br_stall,
    output logic br_valid,
    output logic br_block
);

    br_state_t st_q;
    br_state_t st_d;

    always_comb begin
        st_d     = st_q;
        br_valid = root_valid & st_q.pend;
        br_block = st_q.pend & br_stall;
        if (root_xfer) begin
            st_d.pend = 1'b1;
        end else if (br_valid && !br_stall) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BR_STATE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/efork_any.sv
module efork_any #(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] bits_in,
    output logic             any_out
);

    always_comb begin
        any_out = 1'b0;
        for (int k = 0; k < WIDTH; k++) begin
            any_out = any_out | bits_in[k];
        end
    end

endmodule

// File: rtl/efork.sv
module efork #(
    parameter int BRANCHES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                root_valid,
    output logic                root_stall,
    output logic [BRANCHES-1:0] br_valid,
    input  logic [BRANCHES-1:0] br_stall
);

    logic [BRANCHES-1:0] block_w;
    logic                root_xfer;

    assign root_xfer = root_valid & ~root_stall;

    for (genvar g = 0; g < BRANCHES; g++) begin : g_branch
        efork_branch u_br (
            .clk       (clk),
            .rst_n     (rst_n),
            .root_valid(root_valid),
            .root_xfer (root_xfer),
            .br_stall  (br_stall[g]),
            .br_valid  (br_valid[g]),
            .br_block  (block_w[g])
        );
    end

    efork_any #(.WIDTH(BRANCHES)) u_any (
        .bits_in(block_w),
        .any_out(root_stall)
    );

endmodule

// File: rtl/efork_chk.sv
module efork_chk #(
    parameter int BRANCHES = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                root_valid,
    input logic                root_stall,
    input logic [BRANCHES-1:0] br_valid,
    input logic [BRANCHES-1:0] br_stall
);

    logic root_xfer;
    assign root_xfer = root_valid & ~root_stall;

    // R2: no offer to any branch without a root token
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !root_valid |-> (br_valid == '0));

    // R4: with a token present, stall mirrors an offered branch that refuses
    assert_stall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        root_valid |-> (root_stall == |(br_valid & br_stall)));

    // R5: a branch that took the token is not offered it again while root waits
    assert_no_reoffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (root_valid && root_stall) |=> ((br_valid & $past(br_valid & ~br_stall)) == '0));

    // R6: after a root transfer every branch is offered the next token
    assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        root_xfer |=> (!root_valid || (&br_valid)));

    // R7: branch transfers lead root transfers by 0 or 1
    for (genvar g = 0; g < BRANCHES; g++) begin : g_cnt
        logic [1:0] lead_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lead_q <= 2'd0;
            end else begin
                lead_q <= lead_q + 2'(br_valid[g] & ~br_stall[g]) - 2'(root_xfer);
            end
        end
        assert_token_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
            lead_q <= 2'd1);
    end

endmodule

bind efork efork_chk #(.BRANCHES(BRANCHES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .root_valid(root_valid),
    .root_stall(root_stall),
    .br_valid  (br_valid),
    .br_stall  (br_stall)
);

// File: tb/sim_efork.sv
module sim_efork;

    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         root_valid = 1'b0;
    logic         root_stall;
    logic [N-1:0] br_valid;
    logic [N-1:0] br_stall = '0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model: which branches have taken the current token
    logic [N-1:0] got = '0;
    int           bcnt [N];
    int           rcnt = 0;

    always #2 clk = ~clk;

    efork #(.BRANCHES(N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .root_valid(root_valid),
        .root_stall(root_stall),
        .br_valid  (br_valid),
        .br_stall  (br_stall)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input logic [N-1:0] s,
                        input string tv, input string ts);
        logic [N-1:0] ev;
        logic         es;
        @(negedge clk);
        root_valid = v;
        br_stall   = s;
        #1;
        ev = {N{v}} & ~got;
        es = |(~got & s);
        chk(tv, int'(br_valid), int'(ev));
        chk(ts, int'(root_stall), int'(es));
        if (v && !es) rcnt++;
        for (int i = 0; i < N; i++) begin
            if (ev[i] && !s[i]) bcnt[i]++;
        end
        if (v) begin
            if (!es) got = '0;
            else     got = got | (ev & ~s);
        end
        for (int i = 0; i < N; i++) begin
            chk("R7 lead", ((bcnt[i] - rcnt) >= 0 && (bcnt[i] - rcnt) <= 1) ? 1 : 0, 1);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R0 watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        logic        hold;
        for (int i = 0; i < N; i++) bcnt[i] = 0;
        // R1: reset state seen at the ports while reset is applied
        root_valid = 1'b1;
        br_stall   = '0;
        #5;
        chk("R1 reset valid", int'(br_valid), (1 << N) - 1);
        chk("R1 reset stall", int'(root_stall), 0);
        @(negedge clk);
        rst_n = 1'b1;
        root_valid = 1'b0;

        // R2: no offers while root idle, under each stall pattern
        for (int p = 0; p < (1 << N); p++) step(1'b0, N'(p), "R2 idle valid", "R4 idle stall");

        // R8: all branches stalled at token start -> retry on all
        step(1'b1, '1, "R8 retry valid", "R8 retry stall");
        step(1'b1, '0, "R6 finish valid", "R6 finish stall");

        // R9: idle cycle keeps partial progress
        step(1'b1, 3'b110, "R3 partial valid", "R4 partial stall");
        step(1'b0, 3'b000, "R9 idle valid", "R9 idle stall");
        step(1'b1, 3'b000, "R9 resume valid", "R9 resume stall");
        step(1'b1, 3'b000, "R6 rearm valid", "R6 rearm stall");

        // exhaustive two-cycle stall sweep at token start
        for (int p1 = 0; p1 < (1 << N); p1++) begin
            for (int p2 = 0; p2 < (1 << N); p2++) begin
                step(1'b1, N'(p1), "R3 sweep first valid", "R4 sweep first stall");
                step(1'b1, N'(p2), "R5 sweep second valid", "R4 sweep second stall");
                step(1'b1, '0, "R6 sweep drain valid", "R4 sweep drain stall");
            end
        end

        // pseudo-random traffic obeying token persistence
        lf = 16'hACE1;
        hold = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(hold | lf[0], lf[N+1:2], "R3/R5 random valid", "R4 random stall");
            hold = root_valid & root_stall;
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule